// File: doc/BRIEF.md
# Capacitive Acquisition Start and Count Controller

This block runs a single charge-transfer measurement of a capacitive touch sensor. Software asks for a measurement with a one-cycle start request. The block then either begins at once or waits for a chosen condition on an external sync line. While the measurement runs, it holds a run request to an external pulse generator and counts the transfer pulses that the generator reports. The measurement ends in one of two ways. An external comparator can signal that the sampling capacitor has reached its threshold. Otherwise the pulse count reaches a limit of the form 2^k-1 and the block raises a max-count error.

A held start indication shows that a measurement is pending or in progress. The hardware drops it when the measurement completes, and software can cancel the measurement at any time. The block drives one control output that tells the sensor pads their default state. While idle it applies to every pad; during a measurement the pad logic applies it only to the unused pads. The configuration inputs are captured when a measurement starts, so changing them during a measurement has no effect. Both ending flags stay set until an explicit clear. The final pulse count stays visible until the next start.

Top module: `cap_acq_ctrl`

## Requirements
- R1: While `ctl_en` is low, `start_set` is ignored, `pg_run`, `acq_busy` and `start_flag` are low, and a measurement in progress is dropped on the next clock without setting either flag.
- R2: An accepted `start_set` (enabled, idle) sets `start_flag` on the next clock; the hardware clears it in the same clock edge that sets `eoa_flag` or `mce_flag`.
- R3: `start_cancel` during waiting or running returns the block to idle on the next clock, clears `start_flag` and sets no flag; the count reached so far is kept.
- R4: With `sync_mode`=0, `pg_run` is high from the clock after `start_set`.
- R5: With `sync_mode`=1 and `sync_pol`=0, the block waits until `sync_in` falls (high in one cycle, low in the next); a high level or a rising edge does not start it, and `pg_run` rises one clock after the falling sample.
- R6: With `sync_mode`=1 and `sync_pol`=1, a high level on `sync_in` while waiting starts the run on that clock; if `sync_in` is already high at the start request, `pg_run` is high two clocks after `start_set`.
- R7: `mc_code` 0..6 selects a limit of 255, 511, 1023, 2047, 4095, 8191 or 16383 pulses, and code 7 selects 16383. The pulse that brings `acq_count` to the limit ends the run, and on that clock `mce_flag` is set.
- R8: `eoa_cmp` high while running ends the run on that clock and sets `eoa_flag`. A pulse reported in the same cycle is still counted, and `eoa_cmp` takes priority over the limit.
- R9: `eoa_flag` and `mce_flag` stay set until `flag_clr` is pulsed, which clears both on the next clock.
- R10: `acq_count` is cleared to 0 by an accepted start, counts `pulse_tick` only while running, and holds its value while idle.
- R11: `io_float` is 0 while disabled; while enabled and idle it follows `iodef_float`; during a measurement it holds the value captured at start.
- R12: Changing `sync_mode`, `sync_pol`, `mc_code` or `iodef_float` after the start has no effect on the current measurement.
- R13: `start_set` during a measurement is ignored: the count is not cleared and the run continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Controller enable |
| start_set | input | 1 | One-cycle start request |
| start_cancel | input | 1 | One-cycle cancel of a pending or running measurement |
| sync_mode | input | 1 | 0 start at once, 1 wait for the sync condition |
| sync_pol | input | 1 | 0 falling edge, 1 high level |
| sync_in | input | 1 | External sync line |
| mc_code | input | 3 | Max-count limit select |
| iodef_float | input | 1 | Pad default: 0 drive low, 1 float |
| pulse_tick | input | 1 | One cycle per charge-transfer pulse from the pulse generator |
| eoa_cmp | input | 1 | End-of-measurement comparator |
| flag_clr | input | 1 | Clears both ending flags |
| pg_run | output | 1 | Run request to the pulse generator |
| acq_busy | output | 1 | Waiting for sync or running |
| start_flag | output | 1 | Start indication, cleared by hardware on completion |
| eoa_flag | output | 1 | Sticky end-of-measurement flag |
| mce_flag | output | 1 | Sticky max-count error flag |
| acq_count | output | CNT_W (14) | Pulse count |
| io_float | output | 1 | Pad default state for idle or unused pads |

## Verification
The bench ends measurements exactly at the 255, 1023 and 16383 pulse limits and with code 7. A design with an off-by-one limit, or with the code 7 mapping wrong, would end one pulse early or late and report the wrong count. It changes the limit select, the pad default select and the start request during a run. A design that does not latch its settings would stop early or move `io_float`, and one that re-accepts a start would clear the count. The sync tests hold the line high, raise it, and drop it. A design that takes the wrong edge would start on a level or a rising edge when set for falling, or fail to start on a level that is already high. Disable, cancel, and a comparator hit that arrives together with a pulse check that each end path sets the right flag and keeps the right count.

// File: rtl/cap_acq_pkg.sv
package cap_acq_pkg;

   localparam int MC_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } acq_state_t;

   typedef struct packed {
      logic            sync_mode;
      logic            sync_pol;
      logic [MC_W-1:0] mc_code;
      logic            io_float;
   } acq_cfg_t;

endpackage

// File: rtl/cap_acq_sync_det.sv
module cap_acq_sync_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic pol_level,
   output logic hit
);

   logic s_cur;
   logic s_prev;

   generate
      if (SYNC_STAGES < 0) begin : g_chk
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign s_cur = sync_in;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= sync_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= chain[i-1];
               end
            end
         end
         assign s_cur = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= s_cur;
   end

   assign hit = pol_level ? s_cur : (s_prev & ~s_cur);

   AST_FALL_NEEDS_PRIOR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pol_level) |-> !s_cur) else $error("falling hit while line high"); // R5

endmodule

// File: rtl/cap_acq_limit.sv
module cap_acq_limit
   import cap_acq_pkg::*;
#(
   parameter int CNT_W     = 14,
   parameter int BASE_LOG2 = 8,
   parameter int NUM_CODES = 7
) (
   input  logic [MC_W-1:0]  code,
   output logic [CNT_W-1:0] limit
);

   localparam int TBL_N   = 2 ** MC_W;
   localparam int MAX_EXP = BASE_LOG2 + NUM_CODES - 1;

   logic [CNT_W-1:0] tbl [TBL_N];

   generate
      if (NUM_CODES < 1 || NUM_CODES > TBL_N) begin : g_chk_codes
         $error("NUM_CODES out of range for the code width");
      end
      if (CNT_W < MAX_EXP) begin : g_chk_width
         $error("CNT_W too small for the largest limit");
      end
      if (MAX_EXP > 62) begin : g_chk_exp
         $error("limit exponent too large");
      end
      for (genvar k = 0; k < TBL_N; k++) begin : g_tbl
         localparam int EXP = (k < NUM_CODES) ? (BASE_LOG2 + k) : MAX_EXP;
         localparam logic [63:0] VAL = (64'd1 << EXP) - 64'd1;
         assign tbl[k] = VAL[CNT_W-1:0];
      end
   endgenerate

   assign limit = tbl[code];

endmodule

// File: rtl/cap_acq_counter.sv
module cap_acq_counter #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);

   logic [CNT_W:0] next_val;

   assign next_val = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
   assign at_limit = inc && (next_val == {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (inc)   count <= next_val[CNT_W-1:0];
   end

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clear && count != '1) |=> (count != '0)) else $error("counter wrapped"); // R10

endmodule

// File: rtl/cap_acq_seq.sv
module cap_acq_seq
   import cap_acq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_en,
   input  logic       start_set,
   input  logic       start_cancel,
   input  acq_cfg_t   cfg_live,
   input  logic       sync_hit,
   input  logic       eoa_cmp,
   input  logic       pulse_tick,
   input  logic       at_limit,
   input  logic       flag_clr,
   output acq_state_t state,
   output acq_cfg_t   cfg_q,
   output logic       cnt_clear,
   output logic       cnt_inc,
   output logic       start_flag,
   output logic       eoa_flag,
   output logic       mce_flag
);

   logic accept;

   assign accept    = ctl_en && (state == ST_IDLE) && start_set;
   assign cnt_clear = accept;
   assign cnt_inc   = (state == ST_RUN) && pulse_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cfg_q      <= '0;
         start_flag <= 1'b0;
         eoa_flag   <= 1'b0;
         mce_flag   <= 1'b0;
      end else begin
         if (flag_clr) begin
            eoa_flag <= 1'b0;
            mce_flag <= 1'b0;
         end
         if (!ctl_en) begin
            state      <= ST_IDLE;
            start_flag <= 1'b0;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (start_set) begin
                     cfg_q      <= cfg_live;
                     start_flag <= 1'b1;
                     state      <= cfg_live.sync_mode ? ST_WAIT : ST_RUN;
                  end
               end
               ST_WAIT: begin
                  if (start_cancel) begin
                     state      <= ST_IDLE;
                     start_flag <= 1'b0;
                  end else if (sync_hit) begin
                     state <= ST_RUN;
                  end
               end
               ST_RUN: begin
                  if (start_cancel) begin
                     state      <= ST_IDLE;
                     start_flag <= 1'b0;
                  end else if (eoa_cmp) begin
                     state      <= ST_IDLE;
                     start_flag <= 1'b0;
                     eoa_flag   <= 1'b1;
                  end else if (at_limit) begin
                     state      <= ST_IDLE;
                     start_flag <= 1'b0;
                     mce_flag   <= 1'b1;
                  end
               end
               default: begin
                  state      <= ST_IDLE;
                  start_flag <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> (state == ST_IDLE && !start_flag)) else $error("runs while disabled"); // R1
   AST_START_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eoa_flag) || $rose(mce_flag)) |-> !start_flag) else $error("start kept at end"); // R2
   AST_EOA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (eoa_flag && !flag_clr) |=> eoa_flag) else $error("eoa flag lost"); // R9
   AST_MCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mce_flag && !flag_clr) |=> mce_flag) else $error("mce flag lost"); // R9
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> (state == ST_IDLE || $stable(cfg_q))) else $error("cfg moved"); // R12
   AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |-> start_flag) else $error("busy without start flag"); // R2

endmodule

// File: rtl/cap_acq_ctrl.sv
module cap_acq_ctrl
   import cap_acq_pkg::*;
#(
   parameter int CNT_W       = 14,
   parameter int BASE_LOG2   = 8,
   parameter int NUM_CODES   = 7,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_en,
   input  logic             start_set,
   input  logic             start_cancel,
   input  logic             sync_mode,
   input  logic             sync_pol,
   input  logic             sync_in,
   input  logic [MC_W-1:0]  mc_code,
   input  logic             iodef_float,
   input  logic             pulse_tick,
   input  logic             eoa_cmp,
   input  logic             flag_clr,
   output logic             pg_run,
   output logic             acq_busy,
   output logic             start_flag,
   output logic             eoa_flag,
   output logic             mce_flag,
   output logic [CNT_W-1:0] acq_count,
   output logic             io_float
);

   acq_state_t       state;
   acq_cfg_t         cfg_live;
   acq_cfg_t         cfg_q;
   logic             sync_hit;
   logic             cnt_clear;
   logic             cnt_inc;
   logic             at_limit;
   logic [CNT_W-1:0] limit;

   assign cfg_live.sync_mode = sync_mode;
   assign cfg_live.sync_pol  = sync_pol;
   assign cfg_live.mc_code   = mc_code;
   assign cfg_live.io_float  = iodef_float;

   cap_acq_sync_det #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (sync_in),
      .pol_level (cfg_q.sync_pol),
      .hit       (sync_hit)
   );

   cap_acq_limit #(.CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2), .NUM_CODES(NUM_CODES)) u_limit (
      .code  (cfg_q.mc_code),
      .limit (limit)
   );

   cap_acq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cnt_clear),
      .inc      (cnt_inc),
      .limit    (limit),
      .count    (acq_count),
      .at_limit (at_limit)
   );

   cap_acq_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_en       (ctl_en),
      .start_set    (start_set),
      .start_cancel (start_cancel),
      .cfg_live     (cfg_live),
      .sync_hit     (sync_hit),
      .eoa_cmp      (eoa_cmp),
      .pulse_tick   (pulse_tick),
      .at_limit     (at_limit),
      .flag_clr     (flag_clr),
      .state        (state),
      .cfg_q        (cfg_q),
      .cnt_clear    (cnt_clear),
      .cnt_inc      (cnt_inc),
      .start_flag   (start_flag),
      .eoa_flag     (eoa_flag),
      .mce_flag     (mce_flag)
   );

   assign pg_run   = (state == ST_RUN);
   assign acq_busy = (state != ST_IDLE);

   always_comb begin
      if (!ctl_en)       io_float = 1'b0;
      else if (acq_busy) io_float = cfg_q.io_float;
      else               io_float = iodef_float;
   end

   AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      acq_busy |-> (acq_count <= limit)) else $error("count above limit"); // R7
   AST_MCE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mce_flag) |-> (acq_count == limit)) else $error("mce away from limit"); // R7
   AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!acq_busy && !start_set) |=> $stable(acq_count)) else $error("count moved idle"); // R10
   AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_busy && start_set && !pulse_tick) |=> $stable(acq_count)) else $error("restart cleared count"); // R13

endmodule

// File: tb/cap_acq_ctrl_bench.sv
module cap_acq_ctrl_bench;

   localparam int CNT_W = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_en = 1'b0, start_set = 1'b0, start_cancel = 1'b0;
   logic sync_mode = 1'b0, sync_pol = 1'b0, sync_in = 1'b0;
   logic [2:0] mc_code = 3'd0;
   logic iodef_float = 1'b0, pulse_tick = 1'b0, eoa_cmp = 1'b0, flag_clr = 1'b0;
   logic pg_run, acq_busy, start_flag, eoa_flag, mce_flag, io_float;
   logic [CNT_W-1:0] acq_count;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      bit    eoa;
      bit    mce;
      int    count;
      string req;
   } exp_t;

   exp_t expq[$];

   always #10 clk = ~clk;

   cap_acq_ctrl u_cap_acq_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .start_set(start_set),
      .start_cancel(start_cancel), .sync_mode(sync_mode), .sync_pol(sync_pol),
      .sync_in(sync_in), .mc_code(mc_code), .iodef_float(iodef_float),
      .pulse_tick(pulse_tick), .eoa_cmp(eoa_cmp), .flag_clr(flag_clr),
      .pg_run(pg_run), .acq_busy(acq_busy), .start_flag(start_flag),
      .eoa_flag(eoa_flag), .mce_flag(mce_flag), .acq_count(acq_count),
      .io_float(io_float)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input bit eoa, input bit mce, input int count, input string req);
      exp_t e;
      e.eoa = eoa; e.mce = mce; e.count = count; e.req = req;
      expq.push_back(e);
   endtask

   task automatic kick();
      flag_clr = 1'b1;
      step(1);
      flag_clr  = 1'b0;
      start_set = 1'b1;
      step(1);
      start_set = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         pulse_tick = 1'b1;
         step(1);
      end
      pulse_tick = 1'b0;
   endtask

   task automatic pulse_eoa(input bit with_tick);
      eoa_cmp    = 1'b1;
      pulse_tick = with_tick;
      step(1);
      eoa_cmp    = 1'b0;
      pulse_tick = 1'b0;
   endtask

   // monitor: pops one expectation at every end of a measurement
   bit prev_busy = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_busy && !acq_busy) begin
            if (expq.size() == 0) begin
               chk(1'b0, "SB unexpected end", 1, 0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               chk(eoa_flag == e.eoa, {e.req, " eoa_flag"}, int'(eoa_flag), int'(e.eoa));
               chk(mce_flag == e.mce, {e.req, " mce_flag"}, int'(mce_flag), int'(e.mce));
               chk(int'(acq_count) == e.count, {e.req, " count"}, int'(acq_count), e.count);
               chk(!start_flag, "R2 start_flag at end", int'(start_flag), 0);
            end
         end
         prev_busy = acq_busy;
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      step(2);
      // R1 R11 reset state, disabled
      chk(!pg_run && !acq_busy && !start_flag, "R1 reset idle", int'(acq_busy), 0);
      chk(!eoa_flag && !mce_flag && acq_count == 0, "R10 reset count", int'(acq_count), 0);
      rst_n = 1'b1;
      iodef_float = 1'b1;
      step(1);
      chk(io_float == 1'b0, "R11 disabled io", int'(io_float), 0);
      kick();
      chk(!start_flag && !pg_run && !acq_busy, "R1 start ignored", int'(start_flag), 0);

      // R11 idle follows live select
      ctl_en = 1'b1;
      step(1);
      chk(io_float == 1'b1, "R11 idle float", int'(io_float), 1);
      iodef_float = 1'b0;
      step(1);
      chk(io_float == 1'b0, "R11 idle low", int'(io_float), 0);

      // R4 R12 R13 normal run with mid-run changes, ends by comparator
      iodef_float = 1'b1; mc_code = 3'd1; sync_mode = 1'b0;
      kick();
      chk(pg_run && start_flag, "R4 run next clock", int'(pg_run), 1);
      iodef_float = 1'b0; mc_code = 3'd0; sync_mode = 1'b1;
      ticks(10);
      chk(io_float == 1'b1, "R11 held io", int'(io_float), 1);
      start_set = 1'b1;
      step(1);
      start_set = 1'b0;
      chk(acq_count == 10 && pg_run, "R13 restart ignored", int'(acq_count), 10);
      ticks(300);
      chk(acq_busy && !mce_flag, "R12 limit latched", int'(acq_busy), 1);
      push(1'b1, 1'b0, 310, "R8 eoa end");
      pulse_eoa(1'b0);
      step(3);
      chk(eoa_flag, "R9 eoa sticky", int'(eoa_flag), 1);
      flag_clr = 1'b1;
      step(1);
      flag_clr = 1'b0;
      chk(!eoa_flag && !mce_flag, "R9 clear", int'(eoa_flag), 0);

      // R7 limit 255
      sync_mode = 1'b0; mc_code = 3'd0;
      kick();
      push(1'b0, 1'b1, 255, "R7 limit 255");
      ticks(255);
      step(1);
      ticks(5);
      chk(acq_count == 255 && !pg_run, "R10 hold idle", int'(acq_count), 255);

      // R10 count cleared by start
      mc_code = 3'd2;
      kick();
      chk(acq_count == 0, "R10 cleared at start", int'(acq_count), 0);
      push(1'b0, 1'b1, 1023, "R7 limit 1023");
      ticks(1023);
      step(1);

      // R7 code 7
      mc_code = 3'd7;
      kick();
      push(1'b0, 1'b1, 16383, "R7 code7 limit");
      ticks(16383);
      step(1);

      // R8 comparator with same-cycle pulse, priority over limit
      mc_code = 3'd0;
      kick();
      ticks(254);
      push(1'b1, 1'b0, 255, "R8 eoa with tick");
      pulse_eoa(1'b1);
      step(1);

      // R3 cancel
      kick();
      ticks(5);
      push(1'b0, 1'b0, 5, "R3 cancel");
      start_cancel = 1'b1;
      step(1);
      start_cancel = 1'b0;
      chk(!pg_run && !start_flag, "R3 cancel idle", int'(pg_run), 0);

      // R6 level sync
      sync_mode = 1'b1; sync_pol = 1'b1; sync_in = 1'b0;
      kick();
      step(3);
      chk(acq_busy && !pg_run, "R6 waiting", int'(pg_run), 0);
      sync_in = 1'b1;
      step(1);
      chk(pg_run, "R6 level starts", int'(pg_run), 1);
      push(1'b1, 1'b0, 0, "R6 end");
      pulse_eoa(1'b0);
      step(1);
      kick();
      chk(!pg_run && acq_busy, "R6 pre-high wait one", int'(pg_run), 0);
      step(1);
      chk(pg_run, "R6 pre-high runs", int'(pg_run), 1);
      push(1'b0, 1'b0, 0, "R6 cancel");
      start_cancel = 1'b1;
      step(1);
      start_cancel = 1'b0;

      // R5 falling edge sync
      sync_pol = 1'b1;
      sync_in  = 1'b0;
      sync_pol = 1'b0;
      kick();
      sync_in = 1'b1;
      step(3);
      chk(acq_busy && !pg_run, "R5 rise and level ignored", int'(pg_run), 0);
      sync_pol = 1'b1;
      step(2);
      chk(!pg_run, "R12 pol latched", int'(pg_run), 0);
      sync_in = 1'b0;
      step(1);
      chk(pg_run, "R5 fall starts", int'(pg_run), 1);
      ticks(3);

      // R1 disable mid-run
      push(1'b0, 1'b0, 3, "R1 disable end");
      ctl_en = 1'b0;
      step(1);
      chk(!pg_run && !start_flag && io_float == 1'b0, "R1 dropped", int'(pg_run), 0);
      step(2);

      chk(expq.size() == 0, "SB all ends seen", expq.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule